// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers the interrupt requests of a microcontroller, 36 peripheral lines and 7 software-raised requests, and reduces them to one winner for the processor core. Each source is programmed with an enable, an urgency level from 1 to 7 and a rank from 0 to 8 inside that level. The winner is presented as a 3-bit encoded level, where 0 means no request and 7 is the most urgent. It is accompanied by an 8-bit vector number that is 64 plus the winner's source index. Vector numbers below 64 are never produced.

The core compares the level with its own mask, which is outside this block. When the core takes the interrupt it performs a byte-wide acknowledge read and receives the vector. The encoded level and vector are registered, and they are frozen while the acknowledge read is held. Peripheral requests are level-sensitive: a source keeps requesting until software removes the condition or disables the source. Software sources are raised and dropped through set and clear strobes.

Top module: `prio_irq_enc`

## Requirements
- R1: After reset `irq_level` is 0, `irq_vec` is 255 and `iack_data` is 0. Every source is disabled and no software request is pending, so requests on `periph_req` do not raise the level.
- R2: `irq_level` carries the highest programmed level among enabled, active sources whose level is non-zero. `irq_vec` is 64 plus that winner's index, where peripheral `k` is index `k` and software source `j` is index 36+`j`. A request sampled at a clock edge appears at the outputs after that same edge.
- R3: A source that is disabled, or whose programmed level is 0, never wins, whatever its request.
- R4: Among active sources at the same level, the one with the smaller rank wins. Rank 0 is the most urgent and rank 8 the least.
- R5: Among active sources at the same level and rank, the smaller source index wins.
- R6: A rank written with a value above 8 is stored as 8.
- R7: A pulse on `sw_set[j]` makes software source `j` pending, and it stays pending until a pulse on `sw_clr[j]`. If both are pulsed in the same cycle, the clear wins. Configuration writes and software strobes take effect at the outputs one edge after the edge that captures them.
- R8: With no winner, `irq_level` is 0 and `irq_vec` is 255. With a winner, `irq_vec` lies in 64..64+43-1.
- R9: While `iack_rd` is high at a clock edge, `irq_level` and `irq_vec` keep their values. `iack_data` equals `irq_vec` while `iack_rd` is high and is 0 otherwise.
- R10: A configuration write with `cfg_sel` of 43 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | 36 | Level-sensitive peripheral requests |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 6 | Source index written |
| cfg_en | input | 1 | Enable value written |
| cfg_lvl | input | 3 | Level value written (0 parks the source) |
| cfg_sub | input | 4 | Rank value written (0 most urgent, clamped to 8) |
| sw_set | input | 7 | Software request set strobes |
| sw_clr | input | 7 | Software request clear strobes |
| iack_rd | input | 1 | Acknowledge read in progress |
| irq_level | output | 3 | Encoded level to the core |
| irq_vec | output | 8 | Vector of the current winner |
| iack_data | output | 8 | Byte returned on the acknowledge read |

## Verification
A corrupted enable, level or rank entry shows as a wrong level or vector. It appears one edge after the affected source requests, and only when no more urgent source masks it. The bench therefore raises every source alone, then mixes random configurations and requests against an arithmetic model. A stuck or leaking software pending bit shows one edge after its set or clear strobe. A missing freeze shows as a vector change in the second cycle of a held acknowledge read.

// File: rtl/prio_irq_enc.sv
`timescale 1ns/1ps
module prio_irq_enc #(
  parameter int NP   = 36,
  parameter int NSW  = 7,
  parameter int NSUB = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NP-1:0]                   periph_req,
  input  logic                            cfg_we,
  input  logic [$clog2(NP+NSW)-1:0]       cfg_sel,
  input  logic                            cfg_en,
  input  logic [2:0]                      cfg_lvl,
  input  logic [$clog2(NSUB)-1:0]         cfg_sub,
  input  logic [NSW-1:0]                  sw_set,
  input  logic [NSW-1:0]                  sw_clr,
  input  logic                            iack_rd,
  output logic [2:0]                      irq_level,
  output logic [7:0]                      irq_vec,
  output logic [7:0]                      iack_data
);
  localparam int NSRC  = NP + NSW;
  localparam int IW    = $clog2(NSRC);
  localparam int SUBW  = $clog2(NSUB);
  localparam int KW    = 3 + SUBW;
  localparam int VBASE = 64;

  logic [NSRC-1:0] en_r;
  logic [2:0]      lvl_r [NSRC];
  logic [SUBW-1:0] sub_r [NSRC];
  logic [NSW-1:0]  sw_pend;
  logic [NSRC-1:0] act;
  logic [KW-1:0]   best_key;
  logic [IW-1:0]   best_idx;
  logic [2:0]      lvl_q;
  logic [7:0]      vec_q;

  wire sel_ok = {1'b0, cfg_sel} < (IW+1)'(NSRC);
  wire [SUBW-1:0] sub_w = (cfg_sub > SUBW'(NSUB-1)) ? SUBW'(NSUB-1) : cfg_sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r <= '0;
      for (int i = 0; i < NSRC; i++) begin
        lvl_r[i] <= '0;
        sub_r[i] <= '0;
      end
    end else if (cfg_we && sel_ok) begin
      en_r[cfg_sel]  <= cfg_en;
      lvl_r[cfg_sel] <= cfg_lvl;
      sub_r[cfg_sel] <= sub_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sw_pend <= '0;
    else        sw_pend <= (sw_pend | sw_set) & ~sw_clr;
  end

  assign act = {sw_pend, periph_req};

  always_comb begin
    logic [KW-1:0] k;
    best_key = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      k = {lvl_r[i], SUBW'(NSUB-1) - sub_r[i]};
      if (act[i] && en_r[i] && lvl_r[i] != 3'd0 && k > best_key) begin
        best_key = k;
        best_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= 8'hFF;
    end else if (!iack_rd) begin
      lvl_q <= best_key[KW-1 -: 3];
      vec_q <= (best_key[KW-1 -: 3] == 3'd0) ? 8'hFF : 8'(VBASE) + 8'(best_idx);
    end
  end

  assign irq_level = lvl_q;
  assign irq_vec   = vec_q;
  assign iack_data = iack_rd ? vec_q : 8'h00;
endmodule

// File: rtl/prio_irq_enc_chk.sv
`timescale 1ns/1ps
module prio_irq_enc_chk #(
  parameter int NSRC = 43,
  parameter int NSW  = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iack_rd,
  input logic [NSRC-1:0] act,
  input logic [NSW-1:0]  sw_clr,
  input logic [NSW-1:0]  sw_pend,
  input logic [2:0]      irq_level,
  input logic [7:0]      irq_vec
);
  // R8
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 3'd0 |-> irq_vec == 8'hFF);

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != 3'd0 |-> (irq_vec >= 8'd64 && irq_vec < 8'(64 + NSRC)));

  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_rd |=> ($stable(irq_level) && $stable(irq_vec)));

  // R7
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_clr) |=> ((sw_pend & $past(sw_clr)) == '0));

  // R2
  no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0 && !iack_rd) |=> irq_level == 3'd0);
endmodule

bind prio_irq_enc prio_irq_enc_chk #(.NSRC(NP + NSW), .NSW(NSW)) chk_i (
  .clk(clk), .rst_n(rst_n), .iack_rd(iack_rd), .act(act),
  .sw_clr(sw_clr), .sw_pend(sw_pend),
  .irq_level(irq_level), .irq_vec(irq_vec)
);

// File: tb/prio_irq_enc_test.sv
`timescale 1ns/1ps
module prio_irq_enc_test;
  localparam int NP = 36, NSW = 7, NSRC = 43;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] periph_req = '0;
  logic cfg_we = 0, cfg_en = 0;
  logic [5:0] cfg_sel = '0;
  logic [2:0] cfg_lvl = '0;
  logic [3:0] cfg_sub = '0;
  logic [NSW-1:0] sw_set = '0, sw_clr = '0;
  logic iack_rd = 0;
  logic [2:0] irq_level;
  logic [7:0] irq_vec, iack_data;

  prio_irq_enc uut (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .cfg_sub(cfg_sub),
    .sw_set(sw_set), .sw_clr(sw_clr), .iack_rd(iack_rd),
    .irq_level(irq_level), .irq_vec(irq_vec), .iack_data(iack_data)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_en [NSRC];
  int m_lvl [NSRC];
  int m_sub [NSRC];
  bit m_pend [NSW];

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(bit ok, string r, int a, int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  function automatic void model(output int el, output int ev);
    int bk = 0;
    el = 0; ev = 255;
    for (int i = 0; i < NSRC; i++) begin
      bit a = (i < NP) ? periph_req[i] : m_pend[i-NP];
      if (a && m_en[i] && m_lvl[i] > 0) begin
        int k = m_lvl[i] * 16 + (8 - m_sub[i]);
        if (k > bk) begin bk = k; el = m_lvl[i]; ev = 64 + i; end
      end
    end
  endfunction

  task automatic check_out(string r);
    int el, ev;
    model(el, ev);
    check(irq_level == el, r, irq_level, el);
    check(irq_vec == ev, r, irq_vec, ev);
  endtask

  task automatic cfg(int sel, bit en, int l, int s);
    cfg_we = 1; cfg_sel = 6'(sel); cfg_en = en; cfg_lvl = 3'(l); cfg_sub = 4'(s);
    step();
    cfg_we = 0;
    if (sel < NSRC) begin
      m_en[sel] = en; m_lvl[sel] = l; m_sub[sel] = (s > 8) ? 8 : s;
    end
  endtask

  task automatic sw(logic [NSW-1:0] set_m, logic [NSW-1:0] clr_m);
    sw_set = set_m; sw_clr = clr_m;
    step();
    sw_set = '0; sw_clr = '0;
    for (int j = 0; j < NSW; j++) m_pend[j] = (m_pend[j] | set_m[j]) & ~clr_m[j];
  endtask

  task automatic clear_all();
    periph_req = '0;
    for (int i = 0; i < NSRC; i++) cfg(i, 0, 0, 0);
    sw('0, '1);
    step();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSRC; i++) begin m_en[i] = 0; m_lvl[i] = 0; m_sub[i] = 0; end
    for (int j = 0; j < NSW; j++) m_pend[j] = 0;
    step(); step(); step();
    // R1 reset state
    check(irq_level == 0, "R1", irq_level, 0);
    check(irq_vec == 255, "R1", irq_vec, 255);
    check(iack_data == 0, "R1", iack_data, 0);
    rst_n = 1;
    periph_req = '1;
    step(); step();
    check(irq_level == 0, "R1", irq_level, 0);
    periph_req = '0;

    // R2 every source alone; R3 disabled afterwards
    for (int i = 0; i < NSRC; i++) begin
      cfg(i, 1, (i % 7) + 1, i % 9);
      if (i < NP) periph_req[i] = 1'b1;
      else sw(NSW'(1) << (i - NP), '0);
      step();
      check_out("R2");
      check(irq_vec == 64 + i, "R2", irq_vec, 64 + i);
      cfg(i, 0, (i % 7) + 1, i % 9);
      step();
      check(irq_level == 0, "R3", irq_level, 0);
      periph_req = '0;
      sw('0, '1);
    end

    // R3 level zero with enable set
    cfg(4, 1, 0, 0);
    periph_req[4] = 1'b1;
    step(); step();
    check(irq_level == 0, "R3", irq_level, 0);
    clear_all();

    // R4 rank decides within a level
    cfg(5, 1, 4, 6); cfg(9, 1, 4, 2);
    periph_req[5] = 1'b1; periph_req[9] = 1'b1;
    step();
    check(irq_vec == 64 + 9, "R4", irq_vec, 64 + 9);
    // R5 tie goes to lower index
    cfg(12, 1, 4, 2); periph_req[12] = 1'b1;
    step();
    check(irq_vec == 64 + 9, "R5", irq_vec, 64 + 9);
    // R2 level beats rank
    cfg(20, 1, 5, 8); periph_req[20] = 1'b1;
    step();
    check(irq_vec == 64 + 20, "R2", irq_vec, 64 + 20);
    check(irq_level == 5, "R2", irq_level, 5);
    clear_all();

    // R6 rank clamp
    cfg(1, 1, 3, 8); cfg(2, 1, 3, 12);
    periph_req[1] = 1'b1; periph_req[2] = 1'b1;
    step();
    check(irq_vec == 64 + 1, "R6", irq_vec, 64 + 1);
    clear_all();

    // R7 software pending
    cfg(NP + 3, 1, 6, 0);
    sw(7'b0001000, '0);
    step();
    check(irq_level == 6, "R7", irq_level, 6);
    check(irq_vec == 64 + NP + 3, "R7", irq_vec, 64 + NP + 3);
    step(); step(); step();
    check(irq_level == 6, "R7", irq_level, 6);
    sw(7'b0001000, 7'b0001000);
    step();
    check(irq_level == 0, "R7", irq_level, 0);
    check(irq_vec == 255, "R8", irq_vec, 255);
    clear_all();

    // R9 acknowledge freeze
    cfg(0, 1, 2, 0);
    periph_req[0] = 1'b1;
    step();
    check(irq_level == 2, "R9", irq_level, 2);
    iack_rd = 1;
    periph_req[0] = 1'b0;
    periph_req[7] = 1'b1;
    cfg(7, 1, 7, 0);
    step(); step();
    check(irq_level == 2, "R9", irq_level, 2);
    check(irq_vec == 64, "R9", irq_vec, 64);
    check(iack_data == 64, "R9", iack_data, 64);
    iack_rd = 0;
    step();
    check(iack_data == 0, "R9", iack_data, 0);
    check(irq_vec == 64 + 7, "R9", irq_vec, 64 + 7);
    clear_all();

    // R10 out-of-range selects
    cfg(0, 1, 2, 0);
    periph_req[0] = 1'b1;
    cfg(50, 1, 7, 0); cfg(NSRC, 1, 7, 0); cfg(63, 0, 0, 0);
    step();
    check(irq_level == 2, "R10", irq_level, 2);
    check(irq_vec == 64, "R10", irq_vec, 64);
    clear_all();

    // R2 and R8 random mixtures against the model
    for (int it = 0; it < 300; it++) begin
      if (it % 25 == 0)
        for (int i = 0; i < NSRC; i++)
          cfg(i, 1'($urandom), int'($urandom % 8), int'($urandom % 16));
      periph_req = NP'({$urandom(), $urandom()});
      sw(NSW'($urandom), NSW'($urandom));
      step();
      check_out("R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule